// File: doc/BRIEF.md
# Video-Mode Packet Sequencer for a Serial Display Link

The sequencer produces, line by line, the list of packets that a serial display link carries while it streams video. It walks a whole frame: vertical sync lines, vertical back porch lines, active lines and vertical front porch lines. For each line it emits packet descriptors over a valid/ready handshake. A descriptor holds the identifier byte, the 16-bit word count (zero for short packets), the 6-bit header ECC, a long-packet flag and a flag marking packets whose payload comes from the pixel source. A downstream packer turns these descriptors into bytes on the lanes.

While `run` is high the block starts a frame and captures the whole configuration at that moment. The configuration covers the timing lengths, the sync-pulse or sync-event choice, burst or non-burst filling, skip flags for each horizontal region, the vertical sync-end option, the auto vertical count, the end-of-transmission suppression, the virtual channel and the pixel format. When the last packet of the frame is accepted, the block starts the next frame at once if `run` is still high. Otherwise it goes idle.

Top module: `vid_pkt_seq`

## Requirements
- R1: The identifier byte is {virtual channel, 6-bit data type}, with the channel in bits 7:6. Short packets (sync 0x01/0x11/0x21/0x31, end of transmission 0x08) have `pk_long`=0 and a word count of zero. Null 0x09, blanking 0x19 and pixel packets are long.
- R2: `pk_ecc` bit i is the XOR of the header bits selected by mask i, taken over the 24-bit header {wc[15:0], di[7:0]}. The masks for i=0..5 are 0xF12CB7, 0xF2555B, 0x749A6D, 0xB8E38E, 0xDF03F0 and 0xEFFC00.
- R3: Every line opens with one sync packet. It is 0x01 on the first vertical-sync line, 0x11 on the first line after the vertical-sync region (only if that region is non-empty), and 0x21 on all other lines. Non-active lines then send 0x31 only when the vertical sync-end flag is set.
- R4: An active line sends, in order: the opening sync packet, [blanking of HSA bytes, then 0x31 (sync-pulse mode only)], blanking of HBP bytes, pixel packet, [null of pad bytes], blanking of HFP bytes, then EOT. In sync-event mode no 0x31 appears on active lines.
- R5: Each of the HSA, HBP and HFP skip flags removes that blanking packet. Skipping HSA in sync-pulse mode keeps the 0x31 packet.
- R6: In non-burst mode a null packet (0x09) with the pad word count follows the pixel packet. Burst mode omits it.
- R7: Pixel packets carry `pk_pixel`=1. Format code 0 gives type 0x0E with 2·N bytes, code 1 gives 0x1E with 9·N/4 bytes, code 2 gives 0x2E with 3·N bytes and code 3 gives 0x3E with 3·N bytes, where N is the active pixel count.
- R8: Every line ends with an end-of-transmission packet (0x08) unless the EOT-disable flag is set.
- R9: With auto vertical count set, the frame holds only the active and front-porch lines. The vertical sync and back porch counts are ignored, so no 0x01 or 0x11 packet appears.
- R10: While `pk_valid` is high and `pk_ready` is low, the descriptor and `pk_valid` hold steady.
- R11: Configuration inputs that change after a frame has started do not affect that frame.
- R12: After reset `pk_valid` and `frame_done` are low. `frame_done` pulses for exactly one cycle per frame, after the last packet of the frame is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Start or continue frames |
| cfg_vsa | input | VW | Vertical sync lines |
| cfg_vbp | input | VW | Vertical back porch lines |
| cfg_vact | input | VW | Active lines (at least 1) |
| cfg_vfp | input | VW | Vertical front porch lines |
| cfg_hsa | input | HW | Horizontal sync blanking bytes |
| cfg_hbp | input | HW | Horizontal back porch blanking bytes |
| cfg_hact | input | HW | Active pixels per line |
| cfg_hfp | input | HW | Horizontal front porch blanking bytes |
| cfg_pad | input | HW | Null padding bytes in non-burst mode |
| cfg_pulse | input | 1 | 1 = sync-pulse, 0 = sync-event |
| cfg_burst | input | 1 | 1 = burst filling |
| cfg_skip_hsa | input | 1 | Skip HSA blanking |
| cfg_skip_hbp | input | 1 | Skip HBP blanking |
| cfg_skip_hfp | input | 1 | Skip HFP blanking |
| cfg_hse | input | 1 | Sync-end packet on non-active lines |
| cfg_auto_v | input | 1 | Auto vertical count |
| cfg_no_eot | input | 1 | Suppress end of transmission |
| cfg_vc | input | 2 | Virtual channel |
| cfg_fmt | input | 2 | Pixel format code |
| pk_valid | output | 1 | Descriptor valid |
| pk_ready | input | 1 | Descriptor accepted |
| pk_di | output | 8 | Identifier byte |
| pk_wc | output | 16 | Word count / parameter bytes |
| pk_ecc | output | 6 | Header ECC |
| pk_long | output | 1 | Long packet |
| pk_pixel | output | 1 | Payload from pixel source |
| frame_done | output | 1 | Frame complete pulse |

## Verification
On every cycle the assertions check the handshake hold rule, the one-cycle shape of `frame_done`, the zero word count of short packets, and that pixel packets are long and carry a pixel type. Only the bench scenarios can show the whole packet order of a frame: the choice between 0x01, 0x11 and 0x21 by line, the effect of the skip, burst, sync-end and auto-count flags, the format word counts, and the ECC values against an independent column-code model. They also show that a configuration change in mid-frame has no effect, and they run these checks under back-pressure.

// File: rtl/vid_pkt_seq.sv
module vid_pkt_seq #(
  parameter int HW = 16,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [VW-1:0] cfg_vsa,
  input  logic [VW-1:0] cfg_vbp,
  input  logic [VW-1:0] cfg_vact,
  input  logic [VW-1:0] cfg_vfp,
  input  logic [HW-1:0] cfg_hsa,
  input  logic [HW-1:0] cfg_hbp,
  input  logic [HW-1:0] cfg_hact,
  input  logic [HW-1:0] cfg_hfp,
  input  logic [HW-1:0] cfg_pad,
  input  logic          cfg_pulse,
  input  logic          cfg_burst,
  input  logic          cfg_skip_hsa,
  input  logic          cfg_skip_hbp,
  input  logic          cfg_skip_hfp,
  input  logic          cfg_hse,
  input  logic          cfg_auto_v,
  input  logic          cfg_no_eot,
  input  logic [1:0]    cfg_vc,
  input  logic [1:0]    cfg_fmt,
  output logic          pk_valid,
  input  logic          pk_ready,
  output logic [7:0]    pk_di,
  output logic [15:0]   pk_wc,
  output logic [5:0]    pk_ecc,
  output logic          pk_long,
  output logic          pk_pixel,
  output logic          frame_done
);
  localparam int LW = VW + 2;
  localparam int PW = HW + 4;
  localparam logic [5:0] T_VSS = 6'h01, T_VSE = 6'h11, T_HSS = 6'h21, T_HSE = 6'h31;
  localparam logic [5:0] T_EOT = 6'h08, T_NUL = 6'h09, T_BLK = 6'h19;
  localparam logic [23:0] M0 = 24'hF12CB7, M1 = 24'hF2555B, M2 = 24'h749A6D;
  localparam logic [23:0] M3 = 24'hB8E38E, M4 = 24'hDF03F0, M5 = 24'hEFFC00;

  logic          busy, fd;
  logic [LW-1:0] ln;
  logic [2:0]    slot;

  logic [VW-1:0] s_vsa, s_vbp, s_vact, s_vfp;
  logic [HW-1:0] s_hsa, s_hbp, s_hact, s_hfp, s_pad;
  logic          s_pulse, s_burst, s_skip_hsa, s_skip_hbp, s_skip_hfp, s_hse, s_auto, s_no_eot;
  logic [1:0]    s_vc, s_fmt;

  logic [LW-1:0] vsa_e, vbp_e, act_e, tot;
  assign vsa_e = s_auto ? '0 : LW'(s_vsa);
  assign vbp_e = vsa_e + (s_auto ? '0 : LW'(s_vbp));
  assign act_e = vbp_e + LW'(s_vact);
  assign tot   = act_e + LW'(s_vfp);

  logic in_act, last_ln;
  assign in_act  = (ln >= vbp_e) && (ln < act_e);
  assign last_ln = (ln == tot - 1'b1);

  logic [PW-1:0] px_bytes;
  logic [5:0]    px_type;
  always_comb begin
    case (s_fmt)
      2'd0:    begin px_type = 6'h0E; px_bytes = PW'(s_hact) << 1; end
      2'd1:    begin px_type = 6'h1E; px_bytes = (PW'(s_hact) * PW'(9)) >> 2; end
      2'd2:    begin px_type = 6'h2E; px_bytes = PW'(s_hact) * PW'(3); end
      default: begin px_type = 6'h3E; px_bytes = PW'(s_hact) * PW'(3); end
    endcase
  end

  logic        pres;
  logic [5:0]  typ;
  always_comb begin
    pres = 1'b0; typ = T_HSS; pk_wc = '0; pk_long = 1'b0; pk_pixel = 1'b0;
    case (slot)
      3'd0: begin
        pres = 1'b1;
        if (ln == '0 && vsa_e != '0)         typ = T_VSS;
        else if (ln == vsa_e && vsa_e != '0) typ = T_VSE;
        else                                 typ = T_HSS;
      end
      3'd1: begin pres = in_act & s_pulse & ~s_skip_hsa; typ = T_BLK; pk_wc = 16'(s_hsa); pk_long = 1'b1; end
      3'd2: begin pres = in_act ? s_pulse : s_hse; typ = T_HSE; end
      3'd3: begin pres = in_act & ~s_skip_hbp; typ = T_BLK; pk_wc = 16'(s_hbp); pk_long = 1'b1; end
      3'd4: begin pres = in_act; typ = px_type; pk_wc = 16'(px_bytes); pk_long = 1'b1; pk_pixel = 1'b1; end
      3'd5: begin pres = in_act & ~s_burst; typ = T_NUL; pk_wc = 16'(s_pad); pk_long = 1'b1; end
      3'd6: begin pres = in_act & ~s_skip_hfp; typ = T_BLK; pk_wc = 16'(s_hfp); pk_long = 1'b1; end
      default: begin pres = ~s_no_eot; typ = T_EOT; end
    endcase
  end

  assign pk_di    = {s_vc, typ};
  assign pk_valid = busy & pres;

  logic [23:0] hdr;
  assign hdr    = {pk_wc, pk_di};
  assign pk_ecc = {^(hdr & M5), ^(hdr & M4), ^(hdr & M3), ^(hdr & M2), ^(hdr & M1), ^(hdr & M0)};

  logic adv, end_ln, end_fr, start;
  assign adv    = busy & (pres ? pk_ready : 1'b1);
  assign end_ln = adv & (slot == 3'd7);
  assign end_fr = end_ln & last_ln;
  assign start  = run & (~busy | end_fr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; ln <= '0; slot <= '0; fd <= 1'b0;
    end else begin
      fd <= end_fr;
      if (start) begin
        busy <= 1'b1; ln <= '0; slot <= '0;
      end else begin
        if (end_fr) busy <= 1'b0;
        if (adv) slot <= slot + 1'b1;
        if (end_ln) ln <= ln + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      s_vsa <= cfg_vsa; s_vbp <= cfg_vbp; s_vact <= cfg_vact; s_vfp <= cfg_vfp;
      s_hsa <= cfg_hsa; s_hbp <= cfg_hbp; s_hact <= cfg_hact; s_hfp <= cfg_hfp; s_pad <= cfg_pad;
      s_pulse <= cfg_pulse; s_burst <= cfg_burst; s_skip_hsa <= cfg_skip_hsa;
      s_skip_hbp <= cfg_skip_hbp; s_skip_hfp <= cfg_skip_hfp; s_hse <= cfg_hse;
      s_auto <= cfg_auto_v; s_no_eot <= cfg_no_eot; s_vc <= cfg_vc; s_fmt <= cfg_fmt;
    end
  end

  assign frame_done = fd;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid && !pk_ready |=> pk_valid && $stable(pk_di) && $stable(pk_wc) && $stable(pk_pixel)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R12
  AST_SHORT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid && !pk_long |-> pk_wc == 16'h0000); // R1
  AST_PIXEL_LONG: assert property (@(posedge clk) disable iff (!rst_n)
    pk_valid && pk_pixel |-> pk_long && pk_di[3:0] == 4'hE); // R7
endmodule

// File: tb/vid_pkt_seq_tb_top.sv
`timescale 1ns/1ps
module vid_pkt_seq_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, run;
  logic [11:0] cfg_vsa, cfg_vbp, cfg_vact, cfg_vfp;
  logic [15:0] cfg_hsa, cfg_hbp, cfg_hact, cfg_hfp, cfg_pad;
  logic cfg_pulse, cfg_burst, cfg_skip_hsa, cfg_skip_hbp, cfg_skip_hfp, cfg_hse, cfg_auto_v, cfg_no_eot;
  logic [1:0] cfg_vc, cfg_fmt;
  logic pk_valid, pk_ready, pk_long, pk_pixel, frame_done;
  logic [7:0] pk_di;
  logic [15:0] pk_wc;
  logic [5:0] pk_ecc;

  vid_pkt_seq dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;
  bit bp = 1'b0;
  int cyc = 0;

  logic [7:0]  cap_di [0:255];
  logic [15:0] cap_wc [0:255];
  logic [5:0]  cap_ecc[0:255];
  logic        cap_px [0:255];
  logic        cap_lg [0:255];
  int cap_n = 0, fd_n = 0, fd_at = 0;

  logic [7:0]  exp_di [0:255];
  logic [15:0] exp_wc [0:255];
  logic        exp_px [0:255];
  logic        exp_lg [0:255];
  int exp_n = 0;

  always @(posedge clk) begin
    #1;
    cyc <= cyc + 1;
    pk_ready <= bp ? ((cyc % 3) != 0) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && pk_valid && pk_ready && cap_n < 256) begin
      cap_di[cap_n] = pk_di; cap_wc[cap_n] = pk_wc; cap_ecc[cap_n] = pk_ecc;
      cap_px[cap_n] = pk_pixel; cap_lg[cap_n] = pk_long;
      cap_n = cap_n + 1;
    end
    if (rst_n && frame_done) begin fd_n = fd_n + 1; fd_at = cap_n; end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [5:0] ecc_ref(input logic [23:0] h);
    logic [5:0] col [0:23];
    logic [5:0] e = '0;
    col = '{6'h07,6'h0B,6'h0D,6'h0E,6'h13,6'h15,6'h16,6'h19,6'h1A,6'h1C,6'h23,6'h25,
            6'h26,6'h29,6'h2A,6'h2C,6'h31,6'h32,6'h34,6'h38,6'h1F,6'h2F,6'h37,6'h3B};
    for (int j = 0; j < 24; j++) if (h[j]) e = e ^ col[j];
    return e;
  endfunction

  task automatic push(input logic [5:0] t, input logic [15:0] wc, input bit lg, input bit px);
    exp_di[exp_n] = {cfg_vc, t}; exp_wc[exp_n] = wc; exp_lg[exp_n] = lg; exp_px[exp_n] = px;
    exp_n++;
  endtask

  task automatic build_exp();
    int nv, nb, tot;
    logic [5:0] pt;
    logic [15:0] pb;
    exp_n = 0;
    nv = cfg_auto_v ? 0 : int'(cfg_vsa);
    nb = cfg_auto_v ? 0 : int'(cfg_vbp);
    tot = nv + nb + int'(cfg_vact) + int'(cfg_vfp);
    case (cfg_fmt)
      2'd0: begin pt = 6'h0E; pb = cfg_hact * 2; end
      2'd1: begin pt = 6'h1E; pb = (cfg_hact * 18) / 8; end
      2'd2: begin pt = 6'h2E; pb = cfg_hact * 3; end
      default: begin pt = 6'h3E; pb = cfg_hact * 3; end
    endcase
    for (int k = 0; k < tot; k++) begin
      bit act;
      act = (k >= nv + nb) && (k < nv + nb + int'(cfg_vact));
      if (k == 0 && nv != 0) push(6'h01, 0, 0, 0);
      else if (k == nv && nv != 0) push(6'h11, 0, 0, 0);
      else push(6'h21, 0, 0, 0);
      if (!act) begin
        if (cfg_hse) push(6'h31, 0, 0, 0);
      end else begin
        if (cfg_pulse) begin
          if (!cfg_skip_hsa) push(6'h19, cfg_hsa, 1, 0);
          push(6'h31, 0, 0, 0);
        end
        if (!cfg_skip_hbp) push(6'h19, cfg_hbp, 1, 0);
        push(pt, pb, 1, 1);
        if (!cfg_burst) push(6'h09, cfg_pad, 1, 0);
        if (!cfg_skip_hfp) push(6'h19, cfg_hfp, 1, 0);
      end
      if (!cfg_no_eot) push(6'h08, 0, 0, 0);
    end
  endtask

  task automatic run_frame(input string tag, input bit perturb);
    int w;
    cap_n = 0; fd_n = 0; fd_at = -1;
    run = 1'b1;
    w = 0;
    while (cap_n == 0 && w < 2000) begin @(negedge clk); w++; end
    run = 1'b0;
    if (perturb) begin
      cfg_vc = ~cfg_vc; cfg_fmt = cfg_fmt + 2'd1; cfg_hbp = cfg_hbp + 16'd7;
      cfg_burst = ~cfg_burst; cfg_vfp = cfg_vfp + 12'd2; cfg_no_eot = ~cfg_no_eot;
    end
    w = 0;
    while (fd_n == 0 && w < 20000) begin @(negedge clk); w++; end
    repeat (20) @(negedge clk);
    chk(cap_n == exp_n, {tag, " packet count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++) begin
      chk(cap_di[i] == exp_di[i], {"R1 ", tag, " di"}, cap_di[i], exp_di[i]);
      chk(cap_wc[i] == exp_wc[i] && cap_px[i] == exp_px[i] && cap_lg[i] == exp_lg[i],
          {tag, " wc/flags"}, {cap_wc[i], 3'b0, cap_lg[i], 3'b0, cap_px[i]},
          {exp_wc[i], 3'b0, exp_lg[i], 3'b0, exp_px[i]});
      chk(cap_ecc[i] == ecc_ref({cap_wc[i], cap_di[i]}), "R2 ecc", cap_ecc[i], ecc_ref({cap_wc[i], cap_di[i]}));
    end
    chk(fd_n == 1, "R12 frame_done count", fd_n, 1);
    chk(fd_at == exp_n, "R12 frame_done after last packet", fd_at, exp_n);
  endtask

  task automatic base_cfg();
    cfg_vsa = 2; cfg_vbp = 1; cfg_vact = 2; cfg_vfp = 1;
    cfg_hsa = 4; cfg_hbp = 6; cfg_hact = 5; cfg_hfp = 10; cfg_pad = 3;
    cfg_pulse = 0; cfg_burst = 1; cfg_skip_hsa = 0; cfg_skip_hbp = 0; cfg_skip_hfp = 0;
    cfg_hse = 0; cfg_auto_v = 0; cfg_no_eot = 0; cfg_vc = 2'd1; cfg_fmt = 2'd0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(pk_valid == 1'b0, "R12 reset valid", pk_valid, 0);
    chk(frame_done == 1'b0, "R12 reset frame_done", frame_done, 0);
  endtask

  task automatic t_event_burst();   // R3 R4 R6 R7 R8
    base_cfg(); build_exp(); run_frame("R3/R4/R7/R8 event-burst", 0);
  endtask

  task automatic t_pulse_nonburst(); // R3 R4 R6 R8
    base_cfg(); cfg_pulse = 1; cfg_burst = 0; cfg_hse = 1; cfg_no_eot = 1;
    cfg_vc = 2'd3; cfg_fmt = 2'd1; cfg_hact = 8;
    build_exp(); run_frame("R3/R4/R6/R8 pulse-nonburst", 0);
  endtask

  task automatic t_skips_auto();    // R5 R9
    base_cfg(); cfg_pulse = 1; cfg_skip_hsa = 1; cfg_skip_hbp = 1; cfg_skip_hfp = 1;
    cfg_auto_v = 1; cfg_vsa = 3; cfg_vbp = 2; cfg_fmt = 2'd2; cfg_hact = 4; cfg_vc = 2'd0;
    build_exp(); run_frame("R5/R9 skips-auto", 0);
  endtask

  task automatic t_backpressure();  // R10 R11
    base_cfg(); cfg_fmt = 2'd3; cfg_hact = 6; cfg_burst = 0; cfg_vc = 2'd2; cfg_vsa = 1; cfg_vbp = 0;
    bp = 1'b1;
    build_exp(); run_frame("R10/R11 backpressure-midchange", 1);
    bp = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; base_cfg();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_event_burst();
    t_pulse_nonburst();
    t_skips_auto();
    t_backpressure();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule